// File: doc/BRIEF.md
# I2C Control Register Target

This block is a slave-only I2C-compatible target that holds a small file of 8-bit control registers and exposes their contents to downstream control logic. SCL and SDA are oversampled by a system clock that runs at least eight times faster than SCL. START and STOP conditions are detected from the sampled lines. The block acknowledges only its own 7-bit address (0x6F, so the address byte is 0xDE for a write and 0xDF for a read). It then takes one register-address byte. After that it either accepts one data byte or returns one register byte.

The read sequence has an unusual shape. The address byte carries R/W = 1, and the master still sends a register-address byte in the same transaction. The target then drives the selected register onto SDA, MSB first. No repeated START is used. SDA is driven only by pulling low; the output `sda_pull_o` asks an external open-drain stage to do so.

The register file holds four locations: power/shutdown control, output limiter control, gain control and a test byte. Each location has a parameterised mask of implemented bits. Writes and reads are single-byte; there is no address auto-increment and no clock stretching.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset every register reads 0x00, `ctl_regs_o` is all zero and `sda_pull_o` is 0.
- R2: The target pulls SDA low through the ninth clock of the address byte only when its upper seven bits equal 0x6F. For any other address it gives no acknowledge and keeps SDA released until the next START or STOP.
- R3: START, 0xDE, register address, data, STOP stores the data in the addressed register. Each of the three bytes is acknowledged.
- R4: START, 0xDF, register address (acknowledged), then eight target-driven bits, MSB first, carrying the addressed register. No repeated START is involved.
- R5: Only implemented bits are stored: register 0 keeps bits [3:0], register 1 keeps bits [6:0], register 2 keeps bits [1:0] and register 3 keeps all eight bits. All other bits read 0.
- R6: A write to a register address of 0x04 or above is acknowledged and changes no register. A read of such an address returns 0x00.
- R7: `sda_pull_o` changes only while SCL is low, so SDA is stable during every SCL high phase.
- R8: A STOP before the data byte is complete returns the target to idle with SDA released, and no register changes.
- R9: A START at any point discards the partial transaction, and the next byte is taken as a fresh address byte.
- R10: `ctl_regs_o` carries register n in bits [8n+7:8n], and it changes only when a completed write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 requests that SDA be pulled low (open drain) |
| ctl_regs_o | output | NREG*DW (32) | All registers, register n in bits [8n+7:8n] |

## Verification
One SCL falling edge does two jobs at once. It ends the acknowledge slot that follows the register-address byte of a read. It also starts the first data bit. On that edge the target has to release its ACK pull and, in the same system-clock cycle, replace it with the register's MSB, so a zero MSB keeps SDA low with no glitch. The sweep reads back every register with patterns whose MSB is both 0 and 1, judging the value the bus shows at each SCL high phase. A bench monitor also flags any change of the pull while SCL is high.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_DEV,
    PH_DEV_ACK,
    PH_REG,
    PH_REG_ACK,
    PH_WDAT,
    PH_WDAT_ACK,
    PH_RDAT,
    PH_RDAT_ACK,
    PH_HOLD
  } phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] cur;
  logic [NLINES-1:0] prv;

  assign raw = {sda_i, scl_i};

  // one synchroniser plus a delayed copy per line; idle bus is high
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-1:0], raw[g]};
    end
    assign cur[g] = sh[STAGES-1];
    assign prv[g] = sh[STAGES];
  end

  assign scl_s     = cur[0];
  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_rt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6F,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic          sda_pull,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] reg_addr
);

  localparam int CW = $clog2(DW);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          got_byte;
  logic          rd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      sh       <= '0;
      got_byte <= 1'b0;
      rd_mode  <= 1'b0;
      reg_addr <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        ph       <= PH_DEV;
        cnt      <= '0;
        got_byte <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        ph       <= PH_IDLE;
        cnt      <= '0;
        got_byte <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (ph)
          PH_DEV, PH_REG, PH_WDAT: begin
            if (scl_rise && !got_byte) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DW-1)) got_byte <= 1'b1;
            end else if (scl_fall && got_byte) begin
              got_byte <= 1'b0;
              cnt      <= '0;
              if (ph == PH_DEV) begin
                if (sh[DW-1:1] == DEV_ADDR) begin
                  rd_mode  <= sh[0];
                  sda_pull <= 1'b1;
                  ph       <= PH_DEV_ACK;
                end else begin
                  ph <= PH_HOLD;
                end
              end else if (ph == PH_REG) begin
                reg_addr <= sh;
                sda_pull <= 1'b1;
                ph       <= PH_REG_ACK;
              end else begin
                wr_data  <= sh;
                wr_en    <= 1'b1;
                sda_pull <= 1'b1;
                ph       <= PH_WDAT_ACK;
              end
            end
          end
          PH_DEV_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              ph       <= PH_REG;
            end
          end
          PH_REG_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                // ack release and first data bit share this edge
                sh       <= rd_data;
                sda_pull <= ~rd_data[DW-1];
                cnt      <= '0;
                ph       <= PH_RDAT;
              end else begin
                sda_pull <= 1'b0;
                ph       <= PH_WDAT;
              end
            end
          end
          PH_RDAT: begin
            if (scl_rise && !got_byte) begin
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DW-1)) got_byte <= 1'b1;
            end else if (scl_fall) begin
              if (got_byte) begin
                got_byte <= 1'b0;
                sda_pull <= 1'b0;
                ph       <= PH_RDAT_ACK;
              end else begin
                sh       <= {sh[DW-2:0], 1'b0};
                sda_pull <= ~sh[DW-2];
              end
            end
          end
          PH_RDAT_ACK: begin
            if (scl_fall) ph <= PH_HOLD;
          end
          PH_WDAT_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              ph       <= PH_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int                 NREG  = 4,
  parameter int                 DW    = 8,
  parameter logic [NREG*DW-1:0] WMASK = {8'hFF, 8'h03, 8'h7F, 8'h0F}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [DW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] regs_o
);

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] mem [NREG];
  logic          wr_in;
  logic          rd_in;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign wr_in  = wr_addr < DW'(NREG);
  assign rd_in  = rd_addr < DW'(NREG);
  assign wr_idx = wr_addr[IW-1:0];
  assign rd_idx = rd_addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en && wr_in) begin
      mem[wr_idx] <= wr_data & WMASK[wr_idx*DW +: DW];
    end
  end

  assign rd_data = rd_in ? mem[rd_idx] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = mem[g];
  end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0]         DEV_ADDR    = 7'h6F,
  parameter int                 NREG        = 4,
  parameter int                 DW          = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [NREG*DW-1:0] WMASK       = {8'hFF, 8'h03, 8'h7F, 8'h0F}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NREG*DW-1:0] ctl_regs_o
);

  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] wr_addr;
  logic [DW-1:0] rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR), .DW(DW)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull_o),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .reg_addr  (wr_addr)
  );

  ctl_regfile #(.NREG(NREG), .DW(DW), .WMASK(WMASK)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (wr_addr),
    .rd_data (rd_data),
    .regs_o  (ctl_regs_o)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int                 NREG  = 4,
  parameter int                 DW    = 8,
  parameter logic [NREG*DW-1:0] WMASK = {8'hFF, 8'h03, 8'h7F, 8'h0F}
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_s,
  input logic               stop_det,
  input logic               sda_pull_o,
  input logic               wr_en,
  input logic [DW-1:0]      wr_addr,
  input logic [NREG*DW-1:0] ctl_regs_o
);

  assert_sda_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));

  assert_unused_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_regs_o & ~WMASK) == '0);

  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(ctl_regs_o));

  assert_high_addr_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr >= DW'(NREG))) |=> $stable(ctl_regs_o));

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o);

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NREG(NREG), .DW(DW), .WMASK(WMASK)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .stop_det   (stop_det),
  .sda_pull_o (sda_pull_o),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .ctl_regs_o (ctl_regs_o)
);

// File: tb/i2c_reg_target_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_target_tb_top;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        bus;
  logic        sda_pull_o;
  logic [31:0] ctl_regs_o;

  int checks = 0;
  int errors = 0;
  int r7_viol = 0;
  logic prev_scl = 1'b1;
  logic prev_pull = 1'b0;

  logic [7:0] model [4];

  always #2 clk = ~clk;

  assign bus = sda_m & ~sda_pull_o;

  i2c_reg_target dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (bus),
    .sda_pull_o (sda_pull_o),
    .ctl_regs_o (ctl_regs_o)
  );

  // R7 monitor: pull must not move during an SCL high phase
  always @(negedge clk) begin
    if (!rst && scl && prev_scl && (sda_pull_o != prev_pull)) r7_viol++;
    prev_scl  <= scl;
    prev_pull <= sda_pull_o;
  end

  function automatic logic [7:0] mask_of(input int i);
    case (i)
      0: return 8'h0F;
      1: return 8'h7F;
      2: return 8'h03;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_of(input int i);
    return ctl_regs_o[i*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_tx(input logic b, output logic seen);
    scl = 1'b0; wait_q();
    sda_m = b;  wait_q();
    scl = 1'b1; wait_q();
    seen = bus; wait_q();
  endtask

  task automatic cond_start();
    scl = 1'b0;  wait_q();
    sda_m = 1'b1; wait_q();
    scl = 1'b1;  wait_q();
    sda_m = 1'b0; wait_q();
  endtask

  task automatic cond_stop();
    scl = 1'b0;  wait_q();
    sda_m = 1'b0; wait_q();
    scl = 1'b1;  wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic byte_tx(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_tx(d[i], s);
    bit_tx(1'b1, s);
    ack = ~s;
  endtask

  task automatic bits_tx(input logic [7:0] d, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) bit_tx(d[i], s);
  endtask

  task automatic byte_rx(output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_tx(1'b1, s);
      d[i] = s;
    end
    bit_tx(1'b1, s);
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] ra, input logic [7:0] d,
                          output logic [2:0] acks);
    cond_start();
    byte_tx(dev, acks[2]);
    byte_tx(ra,  acks[1]);
    byte_tx(d,   acks[0]);
    cond_stop();
  endtask

  task automatic do_read(input logic [7:0] dev, input logic [7:0] ra,
                         output logic [7:0] d, output logic [1:0] acks);
    cond_start();
    byte_tx(dev, acks[1]);
    byte_tx(ra,  acks[0]);
    byte_rx(d);
    cond_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [6];
    logic [7:0] ras [6];
    logic [7:0] rd;
    logic [2:0] wa;
    logic [1:0] ra2;
    logic       a;

    pats = '{8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h3C, 8'h81};
    ras  = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'hFF};
    for (int i = 0; i < 4; i++) model[i] = 8'h00;

    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 regs after reset", ctl_regs_o, 32'h0);
    check("R1 sda released", sda_pull_o, 1'b0);

    // R3 R4 R5 R6 R10 sweep over addresses and patterns
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < 6; p++) begin
        do_write(8'hDE, ras[r], pats[p], wa);
        check("R3 write acks", wa, 3'b111);
        if (ras[r] < 4) model[ras[r]] = pats[p] & mask_of(ras[r]);
        for (int k = 0; k < 4; k++)
          check((ras[r] < 4) ? "R5 R10 stored value" : "R6 high write ignored",
                reg_of(k), model[k]);
        do_read(8'hDF, ras[r], rd, ra2);
        check("R4 read acks", ra2, 2'b11);
        check((ras[r] < 4) ? "R4 readback" : "R6 high read zero",
              rd, (ras[r] < 4) ? model[ras[r]] : 8'h00);
      end
    end

    // R2 foreign address: no ack anywhere, registers untouched
    do_write(8'hDC, 8'h00, 8'h0F, wa);
    check("R2 foreign write no ack", wa, 3'b000);
    check("R2 foreign write ignored", reg_of(0), model[0]);
    do_read(8'hDD, 8'h01, rd, ra2);
    check("R2 foreign read no ack", ra2, 2'b00);
    check("R2 foreign read released", rd, 8'hFF);

    // R8 STOP in the middle of the data byte
    cond_start();
    byte_tx(8'hDE, a);
    byte_tx(8'h01, a);
    bits_tx(8'h55, 4);
    cond_stop();
    check("R8 aborted write", reg_of(1), model[1]);
    check("R8 released", sda_pull_o, 1'b0);

    // R9 START inside the register address byte
    cond_start();
    byte_tx(8'hDE, a);
    bits_tx(8'h02, 3);
    cond_start();
    byte_tx(8'hDE, a);
    check("R9 restart address ack", a, 1'b1);
    byte_tx(8'h02, a);
    byte_tx(8'h02, a);
    cond_stop();
    model[2] = 8'h02;
    check("R9 write after restart", reg_of(2), model[2]);

    // R9 START inside the data byte
    cond_start();
    byte_tx(8'hDE, a);
    byte_tx(8'h00, a);
    bits_tx(8'h0C, 5);
    cond_start();
    byte_tx(8'hDE, a);
    byte_tx(8'h03, a);
    byte_tx(8'h77, a);
    cond_stop();
    model[3] = 8'h77;
    check("R9 partial data dropped", reg_of(0), model[0]);
    check("R9 new transaction stored", reg_of(3), model[3]);

    check("R7 no pull change with scl high", r7_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule